// File: doc/BRIEF.md
# MDIO Management Register Access Controller

This block lets software reach the management registers of an Ethernet PHY through two words: a command word it writes and a status word it reads. A write of the command word with a read or write request starts one clause 22 management frame on the two-wire bus. The block generates the management clock by dividing the system clock, shifts out the preamble, start code, opcode and address fields, and then either drives sixteen data bits (write) or releases the data line and samples sixteen bits from the PHY (read).

Completion is reported by two independent flags, one for writes and one for reads. Each flag drops when a command of its own kind is accepted and rises again in the cycle that command's frame ends. Software therefore waits for the relevant flag before issuing the next command of that kind. While a read is pending, the read-data field shows 0xFFFF, the value software assumes for an unfinished read. Only one frame runs at a time. A command strobe that arrives while a frame is on the bus is dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: The command word carries the PHY address in bits 4:0, the register number in bits 12:8 and the write data in bits 31:16. Bit 14 requests a read and bit 13 requests a write; when both are set, the command is a read. Address and register are sent MSB first.
- R2: A frame is 64 bit times long: 32 ones, then start code 0,1, then opcode 1,0 for a read or 0,1 for a write, then the 5-bit PHY address and the 5-bit register number.
- R3: In a write frame, the turnaround bits are driven as 1,0 and are followed by the 16 write-data bits, MSB first.
- R4: MDC is low while idle. Each bit time lasts 2*DIV_HALF system clocks, with MDC low for the first half and high for the second. MDIO changes only at the falling edge of MDC.
- R5: In a read frame, the output enable is low from the first turnaround bit (bit 46) to the end of the frame. The PHY's 16 data bits are sampled on MDC rising edges, MSB first.
- R6: Status bit 0 is write-done, bit 1 is read-ready and bits 31:16 are the last read data. All other bits are zero, and the whole word is zero after reset.
- R7: Accepting a write clears write-done on the next cycle. Accepting a read clears read-ready and sets the read-data field to 0xFFFF. The flag of the other kind is unchanged. A frame's flag and data are set in the cycle after its last bit time ends, which is the same cycle MDC and the output enable return to idle.
- R8: A command strobe that arrives while a frame is running is ignored. This includes a strobe in the final cycle of a frame.
- R9: A command strobe with neither bit 13 nor bit 14 set is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word |
| status | output | 32 | Status word: flags and read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Output enable for the management data line |
| mdio_i | input | 1 | Management data input |

## Verification
The coincidence of interest is a new command strobe arriving in the same cycle that a running frame completes and updates its flag. The bench waits for the reference model to reach the final cycle of a read frame and presents a write strobe exactly there. The per-clock comparison then requires the read-ready flag and data to be set, write-done to keep its old value, and MDC and the output enable to stay idle afterwards. A second strobe issued one cycle later must be accepted normally.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants and types for the MDIO management controller.
// Assumes clause 22 framing only; bit positions here are software visible.
package mdio_mgmt_pkg;
    localparam int CMD_PHY_LSB  = 0;
    localparam int CMD_REG_LSB  = 8;
    localparam int CMD_WR_BIT   = 13;
    localparam int CMD_RD_BIT   = 14;
    localparam int CMD_DAT_LSB  = 16;
    localparam int ADDR_W       = 5;
    localparam int DATA_W       = 16;
    localparam int PRE_LEN      = 32;
    localparam int FRAME_BITS   = 64;
    localparam int TA_IDX       = 46;
    localparam int DATA_IDX     = 48;

    typedef struct packed {
        logic              is_rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regn;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;

    // Serial image of a frame, transmitted from bit FRAME_BITS-1 downward.
    function automatic logic [FRAME_BITS-1:0] frame_image(input mdio_cmd_t c);
        logic [1:0] op;
        logic [1:0] ta;
        op = c.is_rd ? 2'b10 : 2'b01;
        ta = c.is_rd ? 2'b11 : 2'b10;
        return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regn, ta,
                (c.is_rd ? {DATA_W{1'b0}} : c.wdata)};
    endfunction
endpackage

// File: rtl/mdio_cmd_decode.sv
// Splits the command word into fields and decides whether a strobe starts a frame.
// Assumes the framer reports busy for the whole frame, including its final cycle.
module mdio_cmd_decode
    import mdio_mgmt_pkg::*;
(
    input  logic        cmd_wr,
    input  logic [31:0] cmd_data,
    input  logic        busy,
    output logic        accept,
    output mdio_cmd_t   cmd
);
    logic want_rd;
    logic want_wr;

    // Field extraction; a read request outranks a write request.
    always_comb begin
        want_rd   = cmd_data[CMD_RD_BIT];
        want_wr   = cmd_data[CMD_WR_BIT];
        cmd.is_rd = want_rd;
        cmd.phy   = cmd_data[CMD_PHY_LSB +: ADDR_W];
        cmd.regn  = cmd_data[CMD_REG_LSB +: ADDR_W];
        cmd.wdata = cmd_data[CMD_DAT_LSB +: DATA_W];
        accept    = cmd_wr && !busy && (want_rd || want_wr);
    end
endmodule

// File: rtl/mdio_clkdiv.sv
// Produces a one-cycle tick every DIV_HALF system clocks while run is high.
// Each tick marks one MDC edge; the counter restarts whenever run is low.
module mdio_clkdiv #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    // Tick when the count reaches its final value inside a running frame.
    always_comb tick = run && (cnt == LAST);

    // Half-period counter, held at zero outside frames.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/mdio_framer.sv
// Shifts one management frame onto MDIO, toggling MDC on each divider tick.
// Assumes start is only raised while idle. The PHY's bits are captured on MDC rise.
module mdio_framer
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic              done_rd,
    output logic [DATA_W-1:0] rd_word
);
    localparam int BCW = $clog2(FRAME_BITS);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);
    localparam logic [BCW-1:0] TA_POS   = BCW'(TA_IDX);
    localparam logic [BCW-1:0] DAT_POS  = BCW'(DATA_IDX);

    logic [FRAME_BITS-1:0] sreg;
    logic [BCW-1:0]        bitcnt;
    logic                  is_rd;
    logic [DATA_W-1:0]     rsh;
    logic                  rise;
    logic                  fall;

    // Edge events of MDC and end-of-frame detection.
    always_comb begin
        rise    = tick && !mdc;
        fall    = tick && mdc;
        done    = busy && fall && (bitcnt == LAST_BIT);
        done_rd = is_rd;
        rd_word = rsh;
        mdio_o  = busy ? sreg[FRAME_BITS-1] : 1'b1;
        mdio_oe = busy && !(is_rd && (bitcnt >= TA_POS));
    end

    // Frame sequencing: load, toggle MDC, shift on fall, stop after last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            mdc    <= 1'b0;
            bitcnt <= '0;
            sreg   <= '0;
            is_rd  <= 1'b0;
        end else if (start) begin
            busy   <= 1'b1;
            mdc    <= 1'b0;
            bitcnt <= '0;
            sreg   <= frame_image(cmd);
            is_rd  <= cmd.is_rd;
        end else if (busy) begin
            if (tick) mdc <= !mdc;
            if (fall) begin
                if (bitcnt == LAST_BIT) busy <= 1'b0;
                else                    bitcnt <= bitcnt + 1'b1;
                sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
            end
        end
    end

    // Read capture: one PHY bit per MDC rise during the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    rsh <= '0;
        else if (busy && rise && is_rd && bitcnt >= DAT_POS)
                                                       rsh <= {rsh[DATA_W-2:0], mdio_i};
    end
endmodule

// File: rtl/mdio_status.sv
// Holds the write-done and read-ready flags and the last read data.
// Assumes start and done never coincide, since start needs idle and done needs busy.
module mdio_status
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic              done,
    input  logic              done_rd,
    input  logic [DATA_W-1:0] rd_word,
    output logic [31:0]       status
);
    logic              wr_done;
    logic              rd_rdy;
    logic [DATA_W-1:0] rdata;

    // Flag clear on issue, set on completion, per command kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_done <= 1'b0;
            rd_rdy  <= 1'b0;
            rdata   <= '0;
        end else if (start) begin
            if (start_rd) begin
                rd_rdy <= 1'b0;
                rdata  <= '1;
            end else begin
                wr_done <= 1'b0;
            end
        end else if (done) begin
            if (done_rd) begin
                rd_rdy <= 1'b1;
                rdata  <= rd_word;
            end else begin
                wr_done <= 1'b1;
            end
        end
    end

    // Pack the software-visible word.
    always_comb status = {rdata, 14'd0, rd_rdy, wr_done};
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
// Top of the MDIO management controller: decode, clock divider, framer, status.
// Assumes one PHY bus and clause 22 frames; DIV_HALF >= 1 sets the MDC half period.
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_data,
    output logic [31:0] status,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t         cmd;
    logic              accept;
    logic              busy;
    logic              tick;
    logic              frame_done;
    logic              done_rd;
    logic [DATA_W-1:0] rd_word;

    mdio_cmd_decode u_dec (
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .busy(busy),
        .accept(accept), .cmd(cmd)
    );

    mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    mdio_framer u_frm (
        .clk(clk), .rst_n(rst_n), .start(accept), .cmd(cmd), .tick(tick),
        .mdio_i(mdio_i), .busy(busy), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .done(frame_done), .done_rd(done_rd), .rd_word(rd_word)
    );

    mdio_status u_stat (
        .clk(clk), .rst_n(rst_n), .start(accept), .start_rd(cmd.is_rd),
        .done(frame_done), .done_rd(done_rd), .rd_word(rd_word), .status(status)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Property checker for mdio_mgmt_ctrl, attached by bind below.
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic [31:0] cmd_data,
    input logic [31:0] status,
    input logic        mdc,
    input logic        mdio_o,
    input logic        busy,
    input logic        accept,
    input logic        frame_done
);
    a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

    a_r9_no_op_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_data[14:13] == 2'b00) |-> !accept);

    a_r1_zero_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_data == 32'd0) |-> !accept);

    a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r4_data_stable_mdc_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && mdc) |-> $stable(mdio_o));

    a_r7_write_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmd_data[14]) |=> !status[0]);

    a_r7_read_pending_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_data[14]) |=> (!status[1] && status[31:16] == 16'hFFFF));

    a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (status[0] || status[1]));

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:2] == 14'd0);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .status(status), .mdc(mdc), .mdio_o(mdio_o), .busy(busy),
    .accept(accept), .frame_done(frame_done)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
// Bench: behavioural per-clock reference model compared with the DUT on every clock.
module tb_mdio_mgmt_ctrl;
    localparam int DH   = 2;
    localparam int FLEN = 128 * DH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_data = 32'd0;
    logic        mdio_i = 1'b1;
    logic [31:0] status;
    logic        mdc, mdio_o, mdio_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // Reference model state
    bit          m_busy = 0, m_rdop = 0, m_wd = 0, m_rr = 0;
    bit   [15:0] m_rdata = 0, m_resp = 0, phy_resp = 16'h0000;
    bit   [63:0] m_frame = 0;
    int          m_t = 0;

    mdio_mgmt_ctrl #(.DIV_HALF(DH)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .status(status), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Model step at each rising edge, from the inputs the DUT sees there.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_wd = 0; m_rr = 0; m_rdata = 0; m_t = 0;
        end else if (!m_busy) begin
            if (cmd_wr && (cmd_data[13] || cmd_data[14])) begin
                m_rdop  = cmd_data[14];
                m_frame = {32'hFFFF_FFFF, 2'b01, (m_rdop ? 2'b10 : 2'b01),
                           cmd_data[4:0], cmd_data[12:8], 2'b10, cmd_data[31:16]};
                m_resp  = phy_resp;
                m_busy  = 1; m_t = 0;
                if (m_rdop) begin m_rr = 0; m_rdata = 16'hFFFF; end
                else m_wd = 0;
            end
        end else begin
            m_t++;
            if (m_t == FLEN) begin
                m_busy = 0;
                if (m_rdop) begin m_rr = 1; m_rdata = m_resp; end
                else m_wd = 1;
            end
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            finish_run();
        end
    end

    // Compare at the falling edge, then present the PHY's bit for the next rise.
    always @(negedge clk) begin
        int idx;
        bit e_mdc, e_oe;
        idx   = m_t / (2 * DH);
        e_mdc = m_busy && ((m_t % (2 * DH)) >= DH);
        e_oe  = m_busy && !(m_rdop && idx >= 46);
        if (rst_n) begin
            chk(mdc === e_mdc, "R4", "mdc", 32'(mdc), 32'(e_mdc));
            chk(mdio_oe === e_oe, "R5", "mdio_oe", 32'(mdio_oe), 32'(e_oe));
            if (e_oe)
                chk(mdio_o === m_frame[63 - idx],
                    (idx >= 46) ? "R3" : ((idx >= 36) ? "R1" : "R2"),
                    "mdio_o", 32'(mdio_o), 32'(m_frame[63 - idx]));
            chk(status === {m_rdata, 14'd0, m_rr, m_wd},
                (m_rr && m_rdop) ? "R5" : "R7", "status", status,
                {m_rdata, 14'd0, m_rr, m_wd});
        end
        mdio_i = (m_busy && m_rdop && idx >= 48) ? m_resp[15 - (idx - 48)] : 1'b1;
    end

    task automatic issue(input logic [31:0] w);
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_data = w;
        @(posedge clk); #1;
        cmd_wr = 1'b0; cmd_data = 32'd0;
    endtask

    task automatic wait_idle();
        while (m_busy) begin @(posedge clk); #1; end
    endtask

    function automatic logic [31:0] mk(input bit rd, input bit wr, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {d, 1'b0, rd, wr, rg, 3'b000, phy};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state of the status word
        chk(status === 32'd0, "R6", "reset status", status, 32'd0);

        // R1 R2 R3: write frame
        issue(mk(0, 1, 5'h05, 5'h1F, 16'hA55A));
        // R8: strobe mid-frame must be dropped
        repeat (40) @(posedge clk);
        issue(mk(1, 0, 5'h0A, 5'h03, 16'h0000));
        wait_idle();

        // R5 R7: read frame with a PHY answer
        phy_resp = 16'h1234;
        issue(mk(1, 0, 5'h11, 5'h02, 16'h0000));
        wait_idle();

        // R9: strobe without op bits starts nothing
        issue(mk(0, 0, 5'h1F, 5'h1F, 16'hFFFF));
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(mdio_oe === 1'b0 && mdc === 1'b0, "R9", "idle after no-op", {mdc, mdio_oe}, 32'd0);

        // R1: both op bits set gives a read; extreme addresses
        phy_resp = 16'h8001;
        issue(mk(1, 1, 5'h1F, 5'h1F, 16'h5A5A));
        wait_idle();

        // R3: write with all ones and all zeros data
        issue(mk(0, 1, 5'h1F, 5'h00, 16'hFFFF));
        wait_idle();
        issue(mk(0, 1, 5'h00, 5'h1F, 16'h0000));
        wait_idle();

        // R8: strobe in the final cycle of a read frame is ignored
        phy_resp = 16'hFFFF;
        issue(mk(1, 0, 5'h01, 5'h01, 16'h0000));
        while (!(m_busy && m_t == FLEN - 1)) begin @(posedge clk); #1; end
        cmd_wr = 1'b1; cmd_data = mk(0, 1, 5'h02, 5'h04, 16'hC3C3);
        @(posedge clk); #1;
        cmd_wr = 1'b0; cmd_data = 32'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mdio_oe === 1'b0, "R8", "no frame after final-cycle strobe", 32'(mdio_oe), 32'd0);
        chk(status[1:0] === 2'b11, "R8", "flags after coincidence", 32'(status[1:0]), 32'd3);

        // R7: next command one cycle after completion is accepted
        phy_resp = 16'h0000;
        issue(mk(1, 0, 5'h03, 5'h09, 16'h0000));
        wait_idle();
        issue(mk(0, 1, 5'h02, 5'h04, 16'hC3C3));
        wait_idle();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(status === 32'h0000_0003, "R7", "final status", status, 32'h0000_0003);
        finish_run();
    end
endmodule